// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a parallel NOR flash. It decides when an embedded program or erase has finished, and it does this only by watching the toggle status bits. Once the last write strobe of a command sequence has risen, the host gives the block one start pulse. The block then issues byte reads through a request/acknowledge read port, and every completed transaction on that port counts as one status sample. It compares the samples in pairs. If bit 6 stays steady across a pair, the operation is over. If bit 6 is still changing and bit 5 of the second read is high, the block takes one more pair to tell a late finish from a real failure. In sector-check mode, bit 2 is also used, to tell an erase-suspended sector from a sector that is simply done.

The block reports one of three single-cycle results: done, fail or suspended. A poll budget stops a device that never settles. After a fail result the host is expected to reset the device.

Top module: `tbit_poll_ctrl`

## Requirements
- R1: After reset, `busy_o`, `rd_req_o`, `done_o`, `fail_o` and `susp_o` are all low.
- R2: A start in idle raises `busy_o` from the next cycle. `busy_o` stays high until the cycle in which exactly one of `done_o`/`fail_o`/`susp_o` pulses high for one cycle, and `busy_o` is low in that cycle. A start while busy is ignored.
- R3: `rd_req_o` stays high until a cycle with `rd_ack_i` high. Each such cycle is one sample, and `rd_data_i` is taken in that cycle. `rd_addr_o` holds `addr_i` as latched at start for the whole run.
- R4: Samples are taken in pairs. If bit 6 is equal in both samples of a pair and bit 2 does not decide otherwise (R7), the result is done.
- R5: If bit 6 differs within a pair and bit 5 of the second sample is 0, another pair is read.
- R6: If bit 6 differs within a pair and bit 5 of the second sample is 1, exactly one further pair is read. If bit 6 differs again, the result is fail. Otherwise the pair is classified as in R4/R7.
- R7: In sector-check mode (`sect_chk_i` high at start), a pair with bit 6 steady and bit 2 differing gives suspended. A pair with bit 6 differing is treated as an active erase and follows R5/R6.
- R8: Outside sector-check mode, bit 2 has no effect on the result.
- R9: If a pair still toggles with bit 5 low when the sample count has reached `MAX_POLLS`, the result is fail. A steady pair ending on that same sample still gives done.
- R10: Reset during a run returns the block to idle with no result pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin polling (one-cycle pulse) |
| sect_chk_i | input | 1 | Sector-check mode, latched at start |
| addr_i | input | AW | Byte address to poll, latched at start |
| rd_req_o | output | 1 | Read request to the device port |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read completion, data valid this cycle |
| rd_data_i | input | 8 | Status byte returned by the read |
| busy_o | output | 1 | Polling in progress |
| done_o | output | 1 | Operation complete (pulse) |
| fail_o | output | 1 | Operation failed or budget spent (pulse) |
| susp_o | output | 1 | Polled sector is erase-suspended (pulse) |

## Verification
The poll budget running out and the steady-pair completion test can fall on the same sample: the last sample the budget allows is also the second sample of a pair. The bench provokes this with a device model whose bit 6 stops changing exactly at that pair. It then requires done, not fail, with the full budget of samples used. A second case sends a fresh start and a new address in the middle of a run. The bench judges that the start is ignored by watching the sample count and the read address.

// File: rtl/tbp_pkg.sv
// Package: shared state and result encodings and status bit positions for
// the toggle-bit poller. Assumes the device returns its status on an 8-bit bus.
package tbp_pkg;
    localparam int TOG_BIT = 6;   // main toggle bit
    localparam int ERR_BIT = 5;   // exceeded-time flag
    localparam int SEC_BIT = 2;   // per-sector toggle bit

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_A,
        ST_RD_B,
        ST_RC_A,
        ST_RC_B
    } tbp_state_e;

    typedef enum logic [1:0] {
        RES_NONE,
        RES_DONE,
        RES_FAIL,
        RES_SUSP
    } tbp_res_e;
endpackage

// File: rtl/tbp_pair_cmp.sv
// Pair comparator: compares the first and second status samples of a pair.
// Reports toggling of the main bit and, in sector mode only, of the sector bit,
// plus the error flag of the second sample. Purely combinational.
module tbp_pair_cmp
    import tbp_pkg::*;
(
    input  logic [7:0] first_i,
    input  logic [7:0] second_i,
    input  logic       sect_mode_i,
    output logic       main_tog_o,
    output logic       sec_tog_o,
    output logic       err_o
);
    logic [7:0] diff;
    logic       unused_bits;

    // Bitwise change between the two samples of the pair.
    assign diff        = first_i ^ second_i;
    assign main_tog_o  = diff[TOG_BIT];
    assign sec_tog_o   = sect_mode_i & diff[SEC_BIT];
    assign err_o       = second_i[ERR_BIT];
    assign unused_bits = ^{diff[7], diff[4:3], diff[1:0], second_i[7:6], second_i[4:0]};
endmodule

// File: rtl/tbp_budget.sv
// Poll budget: counts completed samples since start and flags when the
// current sample is the last one allowed. Assumes MAX_POLLS >= 2.
module tbp_budget #(
    parameter int MAX_POLLS = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tick_i,
    output logic spent_o
);
    localparam int CW = $clog2(MAX_POLLS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_POLLS);
    localparam logic [CW-1:0] LAST  = CW'(MAX_POLLS - 1);

    logic [CW-1:0] cnt_q;

    // Saturating count of samples, cleared by each accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (clear_i)                    cnt_q <= '0;
        else if (tick_i && cnt_q != LIMIT)   cnt_q <= cnt_q + 1'b1;
    end

    assign spent_o = (cnt_q >= LAST);
endmodule

// File: rtl/tbp_fsm.sv
// Poll sequencer: runs the read port, holds the first sample of each pair,
// and turns the comparator verdict into next state and result pulses.
// Assumes the comparator sees the live second sample in the acknowledge cycle.
module tbp_fsm
    import tbp_pkg::*;
#(
    parameter int AW = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          sect_chk_i,
    input  logic [AW-1:0] addr_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_ack_i,
    input  logic          main_tog_i,
    input  logic          sec_tog_i,
    input  logic          err_i,
    input  logic          spent_i,
    output logic          sect_mode_o,
    output logic          sample_o,
    output logic          clear_o,
    output logic [7:0]    first_o,
    input  logic [7:0]    rd_data_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          fail_o,
    output logic          susp_o
);
    tbp_state_e    st_q, st_d;
    tbp_res_e      res_d;
    logic [AW-1:0] addr_q;
    logic          sect_q;
    logic [7:0]    first_q;
    logic          done_q, fail_q, susp_q;
    tbp_res_e      steady_res;

    assign rd_req_o    = (st_q != ST_IDLE);
    assign busy_o      = rd_req_o;
    assign rd_addr_o   = addr_q;
    assign sect_mode_o = sect_q;
    assign first_o     = first_q;
    assign sample_o    = rd_req_o && rd_ack_i;
    assign clear_o     = (st_q == ST_IDLE) && start_i;
    assign done_o      = done_q;
    assign fail_o      = fail_q;
    assign susp_o      = susp_q;

    // Verdict for a pair whose main bit held still.
    assign steady_res = sec_tog_i ? RES_SUSP : RES_DONE;

    // Next-state and result decision.
    always_comb begin
        st_d  = st_q;
        res_d = RES_NONE;
        unique case (st_q)
            ST_IDLE: if (start_i)  st_d = ST_RD_A;
            ST_RD_A: if (rd_ack_i) st_d = ST_RD_B;
            ST_RD_B: if (rd_ack_i) begin
                if (!main_tog_i)  res_d = steady_res;
                else if (err_i)   st_d  = ST_RC_A;
                else if (spent_i) res_d = RES_FAIL;
                else              st_d  = ST_RD_A;
            end
            ST_RC_A: if (rd_ack_i) st_d = ST_RC_B;
            ST_RC_B: if (rd_ack_i) res_d = main_tog_i ? RES_FAIL : steady_res;
            default: st_d = ST_IDLE;
        endcase
        if (res_d != RES_NONE) st_d = ST_IDLE;
    end

    // State, run context and first-sample capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            addr_q  <= '0;
            sect_q  <= 1'b0;
            first_q <= '0;
        end else begin
            st_q <= st_d;
            if (clear_o) begin
                addr_q <= addr_i;
                sect_q <= sect_chk_i;
            end
            if (sample_o && (st_q == ST_RD_A || st_q == ST_RC_A)) first_q <= rd_data_i;
        end
    end

    // Registered one-cycle result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            susp_q <= 1'b0;
        end else begin
            done_q <= (res_d == RES_DONE);
            fail_q <= (res_d == RES_FAIL);
            susp_q <= (res_d == RES_SUSP);
        end
    end

    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> rd_req_o);

    a_r2_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, fail_o, susp_o}));

    a_r2_idle_on_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fail_o || susp_o) |-> !busy_o);

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fail_o || susp_o) |=> !(done_o || fail_o || susp_o));

    a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(rd_addr_o));

    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);
endmodule

// File: rtl/tbit_poll_ctrl.sv
// Top: toggle-bit completion poller. Wires the sequencer, pair comparator and
// poll budget. Assumes start is given only after the final write strobe.
module tbit_poll_ctrl #(
    parameter int AW        = 22,
    parameter int MAX_POLLS = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          sect_chk_i,
    input  logic [AW-1:0] addr_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_ack_i,
    input  logic [7:0]    rd_data_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          fail_o,
    output logic          susp_o
);
    logic       main_tog, sec_tog, err_flag, spent, sect_mode, sample, clear;
    logic [7:0] first_byte;

    tbp_fsm #(.AW(AW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .sect_chk_i (sect_chk_i),
        .addr_i     (addr_i),
        .rd_req_o   (rd_req_o),
        .rd_addr_o  (rd_addr_o),
        .rd_ack_i   (rd_ack_i),
        .main_tog_i (main_tog),
        .sec_tog_i  (sec_tog),
        .err_i      (err_flag),
        .spent_i    (spent),
        .sect_mode_o(sect_mode),
        .sample_o   (sample),
        .clear_o    (clear),
        .first_o    (first_byte),
        .rd_data_i  (rd_data_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .fail_o     (fail_o),
        .susp_o     (susp_o)
    );

    tbp_pair_cmp u_cmp (
        .first_i    (first_byte),
        .second_i   (rd_data_i),
        .sect_mode_i(sect_mode),
        .main_tog_o (main_tog),
        .sec_tog_o  (sec_tog),
        .err_o      (err_flag)
    );

    tbp_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(clear),
        .tick_i (sample),
        .spent_o(spent)
    );

    // R9: a toggling pair with a clear error flag on the last allowed sample must fail.
    a_r9_budget_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && spent && main_tog && !err_flag && u_fsm.st_q == tbp_pkg::ST_RD_B) |=> fail_o);

    // R10 companion: no result can appear while idle without a preceding sample.
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample) |=> !(done_o || fail_o || susp_o));
endmodule

// File: tb/tbit_poll_ctrl_tb_top.sv
// Bench: device model with programmable toggle stop, error-flag onset, sector
// bit toggling and ack latency; vector table loop plus directed tests.
module tbit_poll_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 22;
    localparam int MAXP       = 8;
    localparam int NV         = 12;

    // Result codes: 1 done, 2 fail, 3 suspended.
    typedef struct packed {
        int       n_tog;
        int       d5_at;
        logic     dq2;
        logic     sect;
        logic [1:0] res;
        int       reads;
        int       ws;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{  0, 99, 1'b0, 1'b0, 2'd1, 2, 0},  // R4 steady at once
        '{  1, 99, 1'b0, 1'b0, 2'd1, 4, 1},  // R5 one more pair
        '{  3, 99, 1'b0, 1'b0, 2'd1, 6, 2},  // R5 two more pairs
        '{100, 99, 1'b0, 1'b0, 2'd2, 8, 0},  // R9 budget spent
        '{100,  1, 1'b0, 1'b0, 2'd2, 4, 1},  // R6 recheck still toggling
        '{  2,  1, 1'b0, 1'b0, 2'd1, 4, 0},  // R6 late completion
        '{  0, 99, 1'b1, 1'b1, 2'd3, 2, 1},  // R7 suspended
        '{  0, 99, 1'b0, 1'b1, 2'd1, 2, 0},  // R7 sector done
        '{  2, 99, 1'b1, 1'b1, 2'd3, 4, 2},  // R7 erase active then suspended
        '{  0, 99, 1'b1, 1'b0, 2'd1, 2, 0},  // R8 bit 2 ignored
        '{  2,  1, 1'b1, 1'b1, 2'd3, 4, 1},  // R6 recheck classified as R7
        '{  6, 99, 1'b0, 1'b0, 2'd1, 8, 0}   // R9 completion on last sample
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          sect_chk_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          rd_req_o;
    logic [AW-1:0] rd_addr_o;
    logic          rd_ack_i = 1'b0;
    logic [7:0]    rd_data_i = '0;
    logic          busy_o, done_o, fail_o, susp_o;

    int n_run = 0, n_fail = 0, cycles = 0;
    int cfg_n = 0, cfg_d5 = 99, cfg_ws = 0;
    logic cfg_dq2 = 1'b0;
    int k_reads = 0, wcnt = 0, addr_err = 0;
    logic [AW-1:0] exp_addr = '0;

    tbit_poll_ctrl #(.AW(AW), .MAX_POLLS(MAXP)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sect_chk_i(sect_chk_i),
        .addr_i(addr_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i), .busy_o(busy_o),
        .done_o(done_o), .fail_o(fail_o), .susp_o(susp_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] dev_byte(int k);
        logic [7:0] b;
        b = 8'h01;
        b[7] = k[1];
        b[6] = (k < cfg_n) ? k[0] : cfg_n[0];
        b[5] = (k >= cfg_d5);
        b[2] = cfg_dq2 ? k[0] : 1'b0;
        return b;
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Device model: answers requests after cfg_ws wait cycles.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                rd_ack_i = 1'b0;
                wcnt = 0;
            end else if (rd_ack_i) begin
                rd_ack_i = 1'b0;
            end else if (rd_req_o) begin
                if (wcnt < cfg_ws) wcnt++;
                else begin
                    rd_ack_i  = 1'b1;
                    rd_data_i = dev_byte(k_reads);
                    if (rd_addr_o !== exp_addr) addr_err++;
                    k_reads++;
                    wcnt = 0;
                end
            end
        end
    end

    // Watchdog.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_run++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
                finish_up();
            end
        end
    end

    task automatic run_one(input vec_t v, input string tag, input logic poke);
        int got, cyc, busy_bad;
        cfg_n = v.n_tog; cfg_d5 = v.d5_at; cfg_dq2 = v.dq2; cfg_ws = v.ws;
        @(negedge clk);
        k_reads = 0; addr_err = 0; got = 0; cyc = 0; busy_bad = 0;
        sect_chk_i = v.sect;
        addr_i = addr_i + 22'h1357;
        exp_addr = addr_i;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b1, {tag, " R2 busy after start"}, int'(busy_o), 1);
        while (got == 0 && cyc < 500) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 5) begin start_i = 1'b1; addr_i = ~addr_i; end
            if (poke && cyc == 6) start_i = 1'b0;
            if (done_o) got = 1;
            else if (fail_o) got = 2;
            else if (susp_o) got = 3;
            else if (!busy_o) busy_bad++;
            if (got != 0 && busy_o) busy_bad++;
        end
        check(got == int'(v.res), {tag, " result"}, got, int'(v.res));
        check(k_reads == v.reads, {tag, " sample count"}, k_reads, v.reads);
        check(busy_bad == 0, {tag, " R2 busy window"}, busy_bad, 0);
        check(addr_err == 0, {tag, " R3 address"}, addr_err, 0);
        @(negedge clk);
        check({done_o, fail_o, susp_o} == 3'b000, {tag, " R2 pulse width"},
              int'({done_o, fail_o, susp_o}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({busy_o, rd_req_o, done_o, fail_o, susp_o} == 5'b0, "R1 reset state",
              int'({busy_o, rd_req_o, done_o, fail_o, susp_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy_o, rd_req_o} == 2'b0, "R1 idle after release", int'({busy_o, rd_req_o}), 0);

        for (int i = 0; i < NV; i++) begin
            run_one(VECS[i], $sformatf("vec%0d", i), 1'b0);
        end

        // R2/R3: start and address change mid-run are ignored (budget run).
        run_one(VECS[3], "R2 start while busy", 1'b1);

        // R10: reset mid-run returns to idle without a result.
        cfg_n = 100; cfg_d5 = 99; cfg_dq2 = 1'b0; cfg_ws = 3;
        @(negedge clk);
        exp_addr = addr_i; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check({busy_o, rd_req_o, done_o, fail_o, susp_o} == 5'b0, "R10 reset mid-run",
              int'({busy_o, rd_req_o, done_o, fail_o, susp_o}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check({busy_o, done_o, fail_o, susp_o} == 4'b0, "R10 stays idle",
              int'({busy_o, done_o, fail_o, susp_o}), 0);

        // R1-style sanity that a fresh run works after the mid-run reset (R4).
        run_one(VECS[0], "R4 after reset", 1'b0);

        finish_up();
    end
endmodule